// File: doc/BRIEF.md
# Mailbox Sender Register Frame

This block is the sending side of an inter-processor mailbox. A sending agent reaches it over a simple 32-bit register bus and posts work by setting bits in the 32-bit status word of one of `NUM_WIN` channel windows. Every status word is driven to a paired receiving frame on `peer_stat`. The receiving side never writes the status directly. Instead it drains bits by pulsing `peer_clr`. When a window that held set bits is drained to zero, the window latches a transmit-done interrupt.

Each window's latched interrupt can be enabled on its own. The enabled window interrupts are gathered into four summary words, one bit per window, and into one interrupt line gated by a frame-level enable. The frame also reports the implemented window count and the revision. It also holds an access request that the receiving side must acknowledge before the sender treats it as ready.

The register bus uses valid/ready. `req_ready` is always high, so a request is accepted in the cycle `req_valid` is high. A read returns on `rsp_valid`/`rsp_rdata` exactly one cycle later. There is no back-pressure on responses, and the requester must take the response in that cycle.

Top module: `mbx_send_frame`

## Requirements
- R1: Window n occupies byte offsets 0x20*n to 0x20*n+0x1F. Its status word reads at +0x00, all status words are zero after reset, and `peer_stat[32n+31:32n]` always equals window n's status word.
- R2: A write to +0x0C of a window ORs the write data into its status word, and zero bits leave the status unchanged. A write to +0x00 has no effect on the status.
- R3: A set bit stays set until the matching `peer_clr` bit is high. If a bus set and a `peer_clr` hit the same bit in the same cycle, the bit ends up set.
- R4: The transmit-done flag is bit 0 of +0x10. It sets in the cycle after one in which the window's status was nonzero and `peer_clr` covered every set bit, whatever is set by the bus in that same cycle.
- R5: Writing 1 to bit 0 of +0x14 clears the transmit-done flag. If a drain occurs in the same cycle, the flag stays set. Bit 0 of +0x18 is a read/write enable for the flag.
- R6: The summary words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC hold bit (n mod 32) of word n/32 for window n. That bit is the window's flag AND its enable.
- R7: Bit 2 of 0xF98 is the read/write combined-interrupt enable. `irq` is that bit AND the OR of all summary bits. Bit 2 of 0xF90 reads the ungated OR of the summary bits.
- R8: 0xF80 bits [6:0] read `NUM_WIN`. 0xFCC reads `MINOR_REV` in bits [3:0] and `MAJOR_REV` in bits [7:4]. With the defaults used here it reads 0x21.
- R9: Bit 0 of 0xF88 is a read/write access request driven on `peer_access_req`. Bit 0 of 0xF8C reads 1 only while the request is 1 and `peer_access_ack` is high.
- R10: Every read yields `rsp_valid` high with data in the following cycle, and `rsp_valid` is low otherwise. Unmapped offsets read zero: windows at or beyond `NUM_WIN`, +0x04/+0x08/+0x0C/+0x14/+0x1C inside a window, 0xF84, 0xF94, 0xFC8 and other frame offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address (bits [1:0] ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read |
| rsp_rdata | output | 32 | Read response data |
| peer_stat | output | 32*NUM_WIN | All status words, window n at bits [32n+31:32n] |
| peer_clr | input | 32*NUM_WIN | Receiving-side clear bits, same layout |
| peer_access_req | output | 1 | Access request to the receiving side |
| peer_access_ack | input | 1 | Acknowledge from the receiving side |
| irq | output | 1 | Combined transmit-done interrupt |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a bus set and a receiving-side clear on the same status bit. The second pair is a drain that latches the transmit-done flag and a bus write that clears that flag. Directed steps provoke each collision on purpose by driving the bus write and `peer_clr` in the same cycle. The random phase hits both collisions repeatedly, because it mixes sparse and full-window clears with set and flag-clear writes. In every case the bench judges the result against its model's fixed priority: the set wins on the status bit, and the drain wins on the flag. It checks the outcome through the window's status and flag reads, `peer_stat` and `irq`.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned MAX_WIN     = 124;
  localparam int unsigned SUM_WORDS   = 4;
  localparam int unsigned SUM_BITS    = SUM_WORDS * WORD_W;

  // word offsets inside one 0x20-byte window (address bits [4:2])
  localparam logic [2:0] WO_STAT = 3'd0;
  localparam logic [2:0] WO_SET  = 3'd3;
  localparam logic [2:0] WO_FLAG = 3'd4;
  localparam logic [2:0] WO_FCLR = 3'd5;
  localparam logic [2:0] WO_FEN  = 3'd6;

  // frame-level byte addresses
  localparam logic [ADDR_W-1:0] FA_CFG    = 12'hF80;
  localparam logic [ADDR_W-1:0] FA_ACCREQ = 12'hF88;
  localparam logic [ADDR_W-1:0] FA_ACCRDY = 12'hF8C;
  localparam logic [ADDR_W-1:0] FA_FSTAT  = 12'hF90;
  localparam logic [ADDR_W-1:0] FA_FEN    = 12'hF98;
  localparam logic [ADDR_W-1:0] FA_SUM0   = 12'hFA0;
  localparam logic [ADDR_W-1:0] FA_REV    = 12'hFCC;

  localparam int unsigned FEN_BIT = 2;
endpackage

// File: rtl/mbx_win_slot.sv
module mbx_win_slot
  import mbx_pkg::*;
#(
  parameter bit HAS_TXIRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [WORD_W-1:0] set_val,
  input  logic [WORD_W-1:0] peer_clr,
  input  logic              fclr_we,
  input  logic              fen_we,
  input  logic              fen_val,
  output logic [WORD_W-1:0] stat_o,
  output logic              flag_o,
  output logic              fen_o
);
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] kept;
  logic              drained;

  assign kept    = stat_q & ~peer_clr;
  assign drained = (stat_q != '0) && (kept == '0);

  // peer clear applied first, bus set last: set wins on a shared bit
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= kept | (set_we ? set_val : '0);
  end
  assign stat_o = stat_q;

  generate
    if (HAS_TXIRQ) begin : g_irq
      logic flag_q;
      logic fen_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
          fen_q  <= 1'b0;
        end else begin
          if (drained)      flag_q <= 1'b1;
          else if (fclr_we) flag_q <= 1'b0;
          if (fen_we)       fen_q  <= fen_val;
        end
      end
      assign flag_o = flag_q;
      assign fen_o  = fen_q;
    end else begin : g_noirq
      assign flag_o = 1'b0;
      assign fen_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mbx_frame_ctl.sv
module mbx_frame_ctl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sum_any,
  input  logic              peer_ack,
  output logic              acc_req,
  output logic              acc_rdy,
  output logic              comb_en,
  output logic              irq
);
  logic acc_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (wr_fire) begin
      if (waddr == FA_ACCREQ) acc_q <= wdata[0];
      if (waddr == FA_FEN)    en_q  <= wdata[FEN_BIT];
    end
  end

  assign acc_req = acc_q;
  assign acc_rdy = acc_q & peer_ack;
  assign comb_en = en_q;
  assign irq     = en_q & sum_any;
endmodule

// File: rtl/mbx_send_frame.sv
module mbx_send_frame
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned MINOR_REV = 1,
  parameter int unsigned MAJOR_REV = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [11:0]               req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  output logic [32*NUM_WIN-1:0]     peer_stat,
  input  logic [32*NUM_WIN-1:0]     peer_clr,
  output logic                      peer_access_req,
  input  logic                      peer_access_ack,
  output logic                      irq
);
  localparam bit          HAS_TXIRQ = (MINOR_REV != 0);
  localparam int unsigned WIN_SPAN  = NUM_WIN * 32;
  localparam logic [6:0]  NWIN_CODE = 7'(NUM_WIN);
  localparam logic [7:0]  REV_CODE  = {4'(MAJOR_REV), 4'(MINOR_REV)};

  logic              wr_fire;
  logic [ADDR_W-1:0] waddr;
  logic [6:0]        a_win;
  logic [2:0]        a_off;
  logic              in_win;

  assign req_ready = 1'b1;
  assign wr_fire   = req_valid & req_write;
  assign waddr     = {req_addr[ADDR_W-1:2], 2'b00};
  assign a_win     = req_addr[11:5];
  assign a_off     = req_addr[4:2];
  assign in_win    = ({20'd0, req_addr} < WIN_SPAN);

  logic [WORD_W-1:0] stat_w [NUM_WIN];
  logic [NUM_WIN-1:0] flag_w;
  logic [NUM_WIN-1:0] fen_w;
  logic [NUM_WIN-1:0] hit_w;

  genvar gw;
  generate
    for (gw = 0; gw < NUM_WIN; gw++) begin : g_win
      assign hit_w[gw] = wr_fire & in_win & (a_win == 7'(gw));
      mbx_win_slot #(.HAS_TXIRQ(HAS_TXIRQ)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (hit_w[gw] & (a_off == WO_SET)),
        .set_val  (req_wdata),
        .peer_clr (peer_clr[gw*32 +: 32]),
        .fclr_we  (hit_w[gw] & (a_off == WO_FCLR) & req_wdata[0]),
        .fen_we   (hit_w[gw] & (a_off == WO_FEN)),
        .fen_val  (req_wdata[0]),
        .stat_o   (stat_w[gw]),
        .flag_o   (flag_w[gw]),
        .fen_o    (fen_w[gw])
      );
      assign peer_stat[gw*32 +: 32] = stat_w[gw];
    end
  endgenerate

  logic [SUM_BITS-1:0] sum_vec;
  logic                sum_any;
  assign sum_vec = SUM_BITS'(flag_w & fen_w);
  assign sum_any = |(flag_w & fen_w);

  logic acc_rdy;
  logic comb_en;

  mbx_frame_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .waddr    (waddr),
    .wdata    (req_wdata),
    .sum_any  (sum_any),
    .peer_ack (peer_access_ack),
    .acc_req  (peer_access_req),
    .acc_rdy  (acc_rdy),
    .comb_en  (comb_en),
    .irq      (irq)
  );

  // read selection
  logic [WORD_W-1:0] sel_stat;
  logic              sel_flag;
  logic              sel_fen;
  always_comb begin
    sel_stat = '0;
    sel_flag = 1'b0;
    sel_fen  = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (a_win == 7'(w)) begin
        sel_stat = stat_w[w];
        sel_flag = flag_w[w];
        sel_fen  = fen_w[w];
      end
    end
  end

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (in_win) begin
      case (a_off)
        WO_STAT: rd_word = sel_stat;
        WO_FLAG: rd_word = {31'd0, sel_flag};
        WO_FEN:  rd_word = {31'd0, sel_fen};
        default: rd_word = '0;
      endcase
    end else begin
      case (waddr)
        FA_CFG:    rd_word = {25'd0, NWIN_CODE};
        FA_ACCREQ: rd_word = {31'd0, peer_access_req};
        FA_ACCRDY: rd_word = {31'd0, acc_rdy};
        FA_FSTAT:  rd_word = {29'd0, sum_any, 2'b00};
        FA_FEN:    rd_word = {29'd0, comb_en, 2'b00};
        FA_REV:    rd_word = {24'd0, REV_CODE};
        default:   rd_word = '0;
      endcase
      for (int s = 0; s < SUM_WORDS; s++) begin
        if (waddr == FA_SUM0 + ADDR_W'(4*s)) rd_word = sum_vec[s*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= (req_valid & ~req_write) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/mbx_send_frame_chk.sv
module mbx_send_frame_chk #(
  parameter int unsigned NUM_WIN = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [32*NUM_WIN-1:0] peer_stat,
  input logic [32*NUM_WIN-1:0] peer_clr,
  input logic                  peer_access_req,
  input logic                  rsp_valid,
  input logic                  irq
);
  // R2: a status bit can only appear after a bus write
  a_r2_set_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((peer_stat & ~$past(peer_stat)) == '0) || $past(req_valid && req_write)));

  // R3: a set bit survives unless the peer cleared it
  a_r3_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(peer_stat) & ~$past(peer_clr)) & ~peer_stat) == '0));

  // R7: irq rises only after a drain or a bus write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|(peer_stat & peer_clr)) || $past(req_valid && req_write)));

  // R9: the access request changes only after a bus write
  a_r9_req_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(peer_access_req) |-> $past(req_valid && req_write));

  // R10: one response per read, one cycle later
  a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind mbx_send_frame mbx_send_frame_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .peer_stat       (peer_stat),
  .peer_clr        (peer_clr),
  .peer_access_req (peer_access_req),
  .rsp_valid       (rsp_valid),
  .irq             (irq)
);

// File: tb/mbx_send_frame_tb.sv
`timescale 1ns/1ps
module mbx_send_frame_tb;
  localparam int NW = 8;
  localparam int CW = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [CW-1:0] peer_stat;
  logic [CW-1:0] peer_clr = '0;
  logic          peer_access_req;
  logic          peer_access_ack = 1'b0;
  logic          irq;

  always #2 clk = ~clk;

  mbx_send_frame #(.NUM_WIN(NW), .MINOR_REV(1), .MAJOR_REV(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .peer_stat(peer_stat),
    .peer_clr(peer_clr), .peer_access_req(peer_access_req),
    .peer_access_ack(peer_access_ack), .irq(irq));

  logic [31:0] ms [NW];
  logic        mf [NW];
  logic        me [NW];
  logic        mfen, macc;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic any_sum();
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) r |= mf[w] & me[w];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [11:0] wa = {a[11:2], 2'b00};
    logic [31:0] r = '0;
    if (int'(a) < NW * 32) begin
      case (a[4:2])
        3'd0: r = ms[a[11:5]];
        3'd4: r = {31'd0, mf[a[11:5]]};
        3'd6: r = {31'd0, me[a[11:5]]};
        default: r = '0;
      endcase
    end else begin
      case (wa)
        12'hF80: r = NW;
        12'hF88: r = {31'd0, macc};
        12'hF8C: r = {31'd0, macc & peer_access_ack};
        12'hF90: r = {29'd0, any_sum(), 2'b00};
        12'hF98: r = {29'd0, mfen, 2'b00};
        12'hFCC: r = 32'h21;
        default: r = '0;
      endcase
      if (wa >= 12'hFA0 && wa <= 12'hFAC)
        for (int n = 0; n < NW; n++)
          if (n / 32 == int'((wa - 12'hFA0) >> 2)) r[n % 32] = mf[n] & me[n];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    logic [11:0] wa = {a[11:2], 2'b00};
    if (int'(a) < NW * 32) begin
      case (a[4:2])
        3'd0: return "R1/R2";
        3'd4: return "R4/R5";
        3'd6: return "R5";
        default: return "R10";
      endcase
    end
    case (wa)
      12'hF80, 12'hFCC: return "R8";
      12'hF88, 12'hF8C: return "R9";
      12'hF90, 12'hF98: return "R7";
      12'hFA0, 12'hFA4, 12'hFA8, 12'hFAC: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step(input bit we, input logic [11:0] a, input logic [31:0] d,
                            input logic [CW-1:0] clr);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] keep;
      logic drain;
      bit hit;
      keep  = ms[w] & ~clr[w*32 +: 32];
      drain = (ms[w] != 0) && (keep == 0);
      hit   = we && int'(a) < NW * 32 && int'(a[11:5]) == w;
      ms[w] = keep | ((hit && a[4:2] == 3'd3) ? d : 32'd0);
      if (drain) mf[w] = 1'b1;
      else if (hit && a[4:2] == 3'd5 && d[0]) mf[w] = 1'b0;
      if (hit && a[4:2] == 3'd6) me[w] = d[0];
    end
    if (we && {a[11:2], 2'b00} == 12'hF98) mfen = d[2];
    if (we && {a[11:2], 2'b00} == 12'hF88) macc = d[0];
  endtask

  task automatic cyc(input bit v, input bit w, input logic [11:0] a,
                     input logic [31:0] d, input logic [CW-1:0] clr);
    logic [31:0] er;
    logic [CW-1:0] ev;
    string t;
    er = exp_rd(a);
    t  = tag_of(a);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; peer_clr = clr;
    model_step(v && w, a, d, clr);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; peer_clr = '0;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, v && !w});
    if (v && !w) chk(t, rsp_rdata, er);
    for (int k = 0; k < NW; k++) ev[k*32 +: 32] = ms[k];
    total++;
    if (peer_stat !== ev) begin
      bad++;
      $display("FAIL R1/R3 peer_stat act=%h exp=%h", peer_stat, ev);
    end
    chk("R7 irq", {31'd0, irq}, {31'd0, mfen & any_sum()});
    chk("R9 peer_access_req", {31'd0, peer_access_req}, {31'd0, macc});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 1, a, d, '0); endtask
  task automatic rd(input logic [11:0] a); cyc(1, 0, a, 32'd0, '0); endtask
  task automatic clr_only(input logic [CW-1:0] c); cyc(0, 0, 12'd0, 32'd0, c); endtask

  function automatic logic [CW-1:0] win_clr(input int w, input logic [31:0] bits);
    logic [CW-1:0] c = '0;
    c[w*32 +: 32] = bits;
    return c;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int w = 0; w < NW; w++) begin ms[w] = 0; mf[w] = 0; me[w] = 0; end
    mfen = 0; macc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 req_ready", {31'd0, req_ready}, 32'd1);

    // reset state, R1, R8, R9
    rd(12'h000); rd(12'h010); rd(12'h018); rd(12'hF80); rd(12'hFCC); rd(12'hF8C);
    // R2: OR-in, zero bits keep, write to status offset ignored
    wr(12'h00C, 32'h5); wr(12'h00C, 32'h30); rd(12'h000);
    wr(12'h000, 32'h0); rd(12'h000);
    wr(12'h0EC, 32'h8000_0001); rd(12'h0E0);  // R1 window 7
    // R5 enable, R7 frame enable
    wr(12'h018, 32'h1); wr(12'hF98, 32'h4);
    // R4: partial clear, no flag; full drain, flag
    clr_only(win_clr(0, 32'h5)); rd(12'h010);
    clr_only(win_clr(0, 32'h30)); rd(12'h010); rd(12'hFA0); rd(12'hF90);
    // R5 clear flag, then drain and clear in the same cycle
    wr(12'h014, 32'h1); rd(12'h010);
    wr(12'h00C, 32'h3);
    cyc(1, 1, 12'h014, 32'h1, win_clr(0, 32'hFFFF_FFFF)); rd(12'h010);
    // R3: set and clear on the same bit
    wr(12'h02C, 32'hF);
    cyc(1, 1, 12'h02C, 32'hF, win_clr(1, 32'hF)); rd(12'h020);
    // R6: window 5 summary bit with flag but no enable, then enable
    wr(12'h0AC, 32'h2); clr_only(win_clr(5, 32'h2)); rd(12'hFA0);
    wr(12'h0B8, 32'h1); rd(12'hFA0); rd(12'hFA4);
    // R7 gate off
    wr(12'hF98, 32'h0); rd(12'hF90); rd(12'hF98);
    // R10 unmapped
    rd(12'h100); rd(12'hF84); rd(12'hF94); rd(12'hFC8); rd(12'h008); rd(12'h00C); rd(12'h014);
    // R9 access handshake
    wr(12'hF88, 32'h1); rd(12'hF8C);
    peer_access_ack = 1'b1; rd(12'hF8C); rd(12'hF88);
    wr(12'hF88, 32'h0); rd(12'hF8C);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [CW-1:0] c;
      logic [11:0] a;
      int op;
      c = '0;
      for (int w = 0; w < NW; w++) begin
        case ($urandom % 6)
          0: c[w*32 +: 32] = 32'hFFFF_FFFF;
          1: c[w*32 +: 32] = $urandom;
          default: c[w*32 +: 32] = '0;
        endcase
      end
      op = $urandom % 10;
      if (op < 6) a = {3'(($urandom % (NW + 1)) >> 1) , 1'b0, 8'd0} | 12'(($urandom % (NW + 1)) << 5) | 12'(($urandom % 8) << 2);
      else if (op < 9) a = 12'hF80 + 12'(($urandom % 20) << 2);
      else a = 12'hF80 + 12'(($urandom % 32) << 2);
      if (int'(a) >= NW * 32 && a < 12'hF80) a = 12'(($urandom % (NW + 1)) << 5) | 12'(($urandom % 8) << 2);
      peer_access_ack = $urandom % 2;
      case ($urandom % 4)
        0: cyc(0, 0, 12'd0, 32'd0, c);
        1: cyc(1, 0, a, 32'd0, c);
        default: cyc(1, 1, a, ($urandom % 3 == 0) ? $urandom : (32'h1 << ($urandom % 32)) | 32'h5, c);
      endcase
    end
    for (int w = 0; w <= NW; w++) rd(12'(w << 5));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule